// File: doc/BRIEF.md
# USB Charging Port Detection Sequencer

This block works out what kind of USB port a device has been plugged into, with no software involved. When the session-valid input rises, it drives a fixed series of register accesses to the PHY's charger-detection logic. First it checks for data pin contact. Then it runs a primary test that separates a plain data port from a charging port. If the primary test finds a charging port, a secondary test then separates a dedicated charger from a charging data port. The block controls the PHY only through a simple one-access-at-a-time register port. It measures the long waits in ticks of a millisecond strobe and the short settle time in clock cycles.

Once the port type is known, the block returns the PHY to normal operation and raises a done flag. It also reports an allowed-current code. A later current change from the enumerating stack is accepted only when a plain data port was found. When the session is lost, any detection in progress is abandoned and the outputs are cleared.

Top module: `usb_chgdet_seq`

## Requirements
- R1: After reset, `chg_type`, `cur_code`, `det_done` and `reg_req` are all 0.
- R2: When `sess_vld` rises, the block reads address 0x04 and writes it back with bits [4:3] set to 01 (non-driving) and every other bit unchanged. It then writes 0x3F to 0x86, 0x1F to 0x92 and 0x1F to 0x95. After that it waits at least `SETTLE_CYC` clock cycles before the next access.
- R3: Contact detection starts with a write of 0x10 to 0x85. The block then reads 0x87 every `POLL_TICKS` ticks. It stops polling on the first read that has bit 1 set, or after `DCD_TRIES` reads without it. It then writes 0x10 to 0x86.
- R4: Primary detection writes 0x02 and then 0x01 to 0x85. The block waits at least `DET_TICKS` ticks and then reads 0x87. If bit 0 is 0, the port is a standard data port (`chg_type` = 1) and the secondary writes are skipped.
- R5: If primary bit 0 is 1, the block writes 0x08, 0x02 and 0x01 to 0x85. It waits at least `DET_TICKS` ticks and reads 0x87. Bit 0 set gives a dedicated charger (`chg_type` = 3); bit 0 clear gives a charging data port (`chg_type` = 2).
- R6: After classification, the block repeats the three clearing writes from R2. It then reads 0x04 and writes it back with bits [4:3] = 00 and the other bits unchanged. Only then is `det_done` set. While `det_done` is high, `chg_type` is never 0.
- R7: When `det_done` rises, `cur_code` is 1 (one unit load) for a standard data port and 2 (maximum charging current) for either charging port.
- R8: A pulse on `upd_vld` copies `upd_code` to `cur_code` only if `det_done` is set and `chg_type` is 1. Otherwise the pulse is ignored.
- R9: When `sess_vld` is low, the next cycle has `chg_type` = 0, `cur_code` = 0, `det_done` = 0 and no request. No further PHY access is made until the session returns.
- R10: Only one access is outstanding at a time. `reg_req` stays high, with address, data and direction held stable, until `reg_done`. It falls in the cycle after `reg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_vld | input | 1 | Session valid; high starts detection, low aborts it |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| reg_req | output | 1 | PHY register access request |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | AW | PHY register address |
| reg_wdata | output | DW | Write data |
| reg_rdata | input | DW | Read data, valid with `reg_done` |
| reg_done | input | 1 | Access completion strobe |
| upd_vld | input | 1 | Current update strobe from the enumerating stack |
| upd_code | input | 2 | Requested current code |
| chg_type | output | 2 | 0 invalid, 1 standard, 2 charging data port, 3 dedicated charger |
| det_done | output | 1 | Classification finished |
| cur_code | output | 2 | 0 none, 1 unit load, 2 maximum charge |

## Verification
An internal step that goes to the wrong place shows up at once on the register port. The write that follows has an unexpected address or value, there are too many or too few status polls, or the gap before the next access is too short. A scoreboard compares every PHY write, in order, against the sequence the requirements call for. A wrong type or current decision appears on `chg_type`/`cur_code` on the edge after the last restore write. A missed abort shows as a stray access, or as a non-zero output, one cycle after session-valid drops.

// File: rtl/usb_chgdet_seq.sv
module usb_chgdet_seq #(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int POLL_TICKS = 100,
  parameter int DET_TICKS  = 40,
  parameter int SETTLE_CYC = 20000,
  parameter int DCD_TRIES  = 6
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sess_vld,
  input  logic          ms_tick,
  output logic          reg_req,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  input  logic          reg_done,
  input  logic          upd_vld,
  input  logic [1:0]    upd_code,
  output logic [1:0]    chg_type,
  output logic          det_done,
  output logic [1:0]    cur_code
);
  localparam int TMAX = (SETTLE_CYC > POLL_TICKS)
                      ? ((SETTLE_CYC > DET_TICKS) ? SETTLE_CYC : DET_TICKS)
                      : ((POLL_TICKS > DET_TICKS) ? POLL_TICKS : DET_TICKS);
  localparam int TW = $clog2(TMAX + 1);
  localparam int RW = $clog2(DCD_TRIES + 1);

  localparam logic [AW-1:0] A_FCTL = AW'('h04);
  localparam logic [AW-1:0] A_CTL  = AW'('h85);
  localparam logic [AW-1:0] A_CLR  = AW'('h86);
  localparam logic [AW-1:0] A_STS  = AW'('h87);
  localparam logic [AW-1:0] A_LAT  = AW'('h92);
  localparam logic [AW-1:0] A_EN   = AW'('h95);
  localparam logic [DW-1:0] OPM_MSK  = DW'('h18);
  localparam logic [DW-1:0] OPM_NDRV = DW'('h08);

  localparam logic [1:0] T_NONE = 2'd0, T_SDP = 2'd1, T_CDP = 2'd2, T_DCP = 2'd3;
  localparam logic [1:0] C_ZERO = 2'd0, C_UNIT = 2'd1, C_MAX = 2'd2;

  localparam logic [2:0] OP_IDLE = 3'd0, OP_WR = 3'd1, OP_RD = 3'd2,
                         OP_CYC = 3'd3, OP_TICK = 3'd4, OP_DONE = 3'd5;

  // step groups: 0-5 block on, 6-8 contact wait, 9-13 primary,
  // 14-18 secondary, 19-23 block off, 24 detected
  localparam logic [4:0] S_DCD_ON = 5'd6,  S_POLL_W = 5'd7,  S_POLL = 5'd8,
                         S_PRI_RD = 5'd13, S_SEC_RD = 5'd18, S_OFF  = 5'd19,
                         S_LAST   = 5'd23, S_DONE   = 5'd24, S_IDLE = 5'd31;

  logic [4:0]    step, nxt;
  logic [2:0]    op;
  logic [TW-1:0] tmr, wlen;
  logic [RW-1:0] tries;
  logic [DW-1:0] rd_q;

  wire           acc_ok  = reg_req && reg_done;
  wire [RW-1:0]  tries_n = tries + 1'b1;

  assign reg_we = (op == OP_WR);

  always_comb begin
    op        = OP_IDLE;
    reg_addr  = '0;
    reg_wdata = '0;
    wlen      = '0;
    nxt       = step + 5'd1;
    case (step)
      5'd0:  begin op = OP_RD; reg_addr = A_FCTL; end
      5'd1:  begin op = OP_WR; reg_addr = A_FCTL; reg_wdata = (rd_q & ~OPM_MSK) | OPM_NDRV; end
      5'd2:  begin op = OP_WR; reg_addr = A_CLR;  reg_wdata = DW'('h3F); end
      5'd3:  begin op = OP_WR; reg_addr = A_LAT;  reg_wdata = DW'('h1F); end
      5'd4:  begin op = OP_WR; reg_addr = A_EN;   reg_wdata = DW'('h1F); end
      5'd5:  op = OP_CYC;
      5'd6:  begin op = OP_WR; reg_addr = A_CTL;  reg_wdata = DW'('h10); end
      5'd7:  begin op = OP_TICK; wlen = TW'(POLL_TICKS); end
      5'd8:  begin
               op = OP_RD; reg_addr = A_STS;
               nxt = (reg_rdata[1] || tries_n == RW'(DCD_TRIES)) ? 5'd9 : S_POLL_W;
             end
      5'd9:  begin op = OP_WR; reg_addr = A_CLR;  reg_wdata = DW'('h10); end
      5'd10: begin op = OP_WR; reg_addr = A_CTL;  reg_wdata = DW'('h02); end
      5'd11: begin op = OP_WR; reg_addr = A_CTL;  reg_wdata = DW'('h01); end
      5'd12: begin op = OP_TICK; wlen = TW'(DET_TICKS); end
      5'd13: begin op = OP_RD; reg_addr = A_STS; nxt = reg_rdata[0] ? 5'd14 : S_OFF; end
      5'd14: begin op = OP_WR; reg_addr = A_CTL;  reg_wdata = DW'('h08); end
      5'd15: begin op = OP_WR; reg_addr = A_CTL;  reg_wdata = DW'('h02); end
      5'd16: begin op = OP_WR; reg_addr = A_CTL;  reg_wdata = DW'('h01); end
      5'd17: begin op = OP_TICK; wlen = TW'(DET_TICKS); end
      5'd18: begin op = OP_RD; reg_addr = A_STS; end
      5'd19: begin op = OP_WR; reg_addr = A_CLR;  reg_wdata = DW'('h3F); end
      5'd20: begin op = OP_WR; reg_addr = A_LAT;  reg_wdata = DW'('h1F); end
      5'd21: begin op = OP_WR; reg_addr = A_EN;   reg_wdata = DW'('h1F); end
      5'd22: begin op = OP_RD; reg_addr = A_FCTL; end
      5'd23: begin op = OP_WR; reg_addr = A_FCTL; reg_wdata = rd_q & ~OPM_MSK; end
      S_DONE: begin op = OP_DONE; nxt = S_DONE; end
      default: begin op = OP_IDLE; nxt = 5'd0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step     <= S_IDLE;
      reg_req  <= 1'b0;
      tmr      <= '0;
      tries    <= '0;
      rd_q     <= '0;
      chg_type <= T_NONE;
      det_done <= 1'b0;
      cur_code <= C_ZERO;
    end else if (!sess_vld) begin
      step     <= S_IDLE;
      reg_req  <= 1'b0;
      tmr      <= '0;
      tries    <= '0;
      chg_type <= T_NONE;
      det_done <= 1'b0;
      cur_code <= C_ZERO;
    end else begin
      case (op)
        OP_IDLE: begin
          step <= nxt;
          tmr  <= '0;
        end
        OP_WR, OP_RD: begin
          if (acc_ok) begin
            reg_req <= 1'b0;
            step    <= nxt;
            tmr     <= '0;
            if (op == OP_RD) rd_q <= reg_rdata;
            if (step == S_DCD_ON) tries <= '0;
            if (step == S_POLL) tries <= tries_n;
            if (step == S_PRI_RD && !reg_rdata[0]) chg_type <= T_SDP;
            if (step == S_SEC_RD) chg_type <= reg_rdata[0] ? T_DCP : T_CDP;
            if (step == S_LAST) begin
              det_done <= 1'b1;
              cur_code <= (chg_type == T_SDP) ? C_UNIT : C_MAX;
            end
          end else begin
            reg_req <= 1'b1;
          end
        end
        OP_CYC: begin
          if (tmr == TW'(SETTLE_CYC - 1)) begin
            step <= nxt;
            tmr  <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        OP_TICK: begin
          if (ms_tick) begin
            if (tmr == wlen - 1'b1) begin
              step <= nxt;
              tmr  <= '0;
            end else begin
              tmr <= tmr + 1'b1;
            end
          end
        end
        OP_DONE: begin
          if (upd_vld && chg_type == T_SDP) cur_code <= upd_code;
        end
        default: step <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/usb_chgdet_seq_chk.sv
module usb_chgdet_seq_chk #(
  parameter int AW = 8,
  parameter int DW = 8
)(
  input logic          clk,
  input logic          rst_n,
  input logic          sess_vld,
  input logic          reg_req,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic [DW-1:0] reg_wdata,
  input logic          reg_done,
  input logic          upd_vld,
  input logic [1:0]    chg_type,
  input logic          det_done,
  input logic [1:0]    cur_code
);
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n || !sess_vld)
    reg_req && !reg_done |=> reg_req && $stable(reg_addr) && $stable(reg_wdata) && $stable(reg_we));

  assert_req_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && reg_done |=> !reg_req);

  assert_abort_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sess_vld |=> chg_type == 2'd0 && cur_code == 2'd0 && !det_done && !reg_req);

  assert_done_typed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    det_done |-> chg_type != 2'd0);

  assert_cur_select_R7: assert property (@(posedge clk) disable iff (!rst_n || !sess_vld)
    $rose(det_done) |-> cur_code == ((chg_type == 2'd1) ? 2'd1 : 2'd2));

  assert_upd_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n || !sess_vld)
    det_done && chg_type != 2'd1 |=> $stable(cur_code));

  assert_type_held_R6: assert property (@(posedge clk) disable iff (!rst_n || !sess_vld)
    det_done |=> $stable(chg_type) && det_done);

  assert_quiet_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    det_done |-> !reg_req);
endmodule

bind usb_chgdet_seq usb_chgdet_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sess_vld(sess_vld), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_done(reg_done), .upd_vld(upd_vld),
  .chg_type(chg_type), .det_done(det_done), .cur_code(cur_code)
);

// File: tb/sim_usb_chgdet_seq.sv
`timescale 1ns/1ps
module sim_usb_chgdet_seq;
  localparam int POLL = 5, DET = 3, SETTLE = 10, TRIES = 6;

  logic       clk = 0, rst_n = 0, sess_vld = 0, ms_tick = 0;
  logic       reg_req, reg_we, reg_done = 0, upd_vld = 0;
  logic [7:0] reg_addr, reg_wdata, reg_rdata = 0;
  logic [1:0] upd_code = 0, chg_type, cur_code;
  logic       det_done;

  usb_chgdet_seq #(.POLL_TICKS(POLL), .DET_TICKS(DET), .SETTLE_CYC(SETTLE), .DCD_TRIES(TRIES)) u0 (
    .clk(clk), .rst_n(rst_n), .sess_vld(sess_vld), .ms_tick(ms_tick),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_done(reg_done), .upd_vld(upd_vld), .upd_code(upd_code),
    .chg_type(chg_type), .det_done(det_done), .cur_code(cur_code));

  initial forever #2.5ns clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, tick_cnt = 0;
  int polls = 0, t_w95 = 0, settle_gap = 0, t_pri = 0, pri_gap = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  reg04 = 8'h45;
  bit contact = 0, pri_res = 0, sec_res = 0, sec_mode = 0, in_dcd = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [7:0] d, input string t);
    exp_q.push_back({a, d});
    tag_q.push_back(t);
  endtask

  // driver: expected PHY write sequence
  task automatic push_seq(input bit pri);
    logic [7:0] nd, nrm;
    nd  = (reg04 & ~8'h18) | 8'h08;
    nrm = reg04 & ~8'h18;
    put(8'h04, nd, "R2"); put(8'h86, 8'h3F, "R2"); put(8'h92, 8'h1F, "R2"); put(8'h95, 8'h1F, "R2");
    put(8'h85, 8'h10, "R3"); put(8'h86, 8'h10, "R3");
    put(8'h85, 8'h02, "R4"); put(8'h85, 8'h01, "R4");
    if (pri) begin put(8'h85, 8'h08, "R5"); put(8'h85, 8'h02, "R5"); put(8'h85, 8'h01, "R5"); end
    put(8'h86, 8'h3F, "R6"); put(8'h92, 8'h1F, "R6"); put(8'h95, 8'h1F, "R6"); put(8'h04, nrm, "R6");
  endtask

  task automatic phy_write(input logic [7:0] a, input logic [7:0] d);
    logic [15:0] e;
    string t;
    if (exp_q.size() == 0) begin
      chk(0, "R9 unexpected write", {a, d}, 0);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(e == {a, d}, t, {a, d}, e);
    end
    case (a)
      8'h04: reg04 = d;
      8'h85: begin
        if (d == 8'h08) sec_mode = 1;
        if (d == 8'h10) begin in_dcd = 1; sec_mode = 0; settle_gap = cyc - t_w95; end
        if (d == 8'h01) t_pri = tick_cnt;
      end
      8'h86: if (d == 8'h10) in_dcd = 0;
      8'h95: t_w95 = cyc;
      default: ;
    endcase
  endtask

  // PHY model and scoreboard monitor
  initial begin
    int lat;
    lat = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (reg_done) reg_done = 0;
      else if (reg_req) begin
        if (lat < 1) lat++;
        else begin
          lat = 0;
          reg_done = 1;
          if (reg_we) phy_write(reg_addr, reg_wdata);
          else if (reg_addr == 8'h04) reg_rdata = reg04;
          else if (reg_addr == 8'h87) begin
            reg_rdata = {6'b0, contact, sec_mode ? sec_res : pri_res};
            if (in_dcd) polls++;
            else pri_gap = tick_cnt - t_pri;
          end else reg_rdata = 8'h00;
        end
      end else lat = 0;
    end
  end

  initial forever begin
    repeat (3) @(negedge clk);
    ms_tick = 1; tick_cnt++;
    @(negedge clk);
    ms_tick = 0;
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  task automatic wait_done();
    for (int i = 0; i < 20000 && !det_done; i++) @(negedge clk);
  endtask

  task automatic run_case(input bit c, input bit p, input bit s, input logic [1:0] et,
                          input logic [1:0] ec, input int ep);
    contact = c; pri_res = p; sec_res = s; polls = 0;
    push_seq(p);
    @(negedge clk); sess_vld = 1;
    wait_done();
    chk(det_done == 1, "R6 done", det_done, 1);
    chk(chg_type == et, p ? "R5 type" : "R4 type", chg_type, et);
    chk(cur_code == ec, "R7 current", cur_code, ec);
    chk(polls == ep, "R3 poll count", polls, ep);
    chk(settle_gap >= SETTLE, "R2 settle", settle_gap, SETTLE);
    chk(pri_gap >= DET, "R4 detect wait", pri_gap, DET);
    chk(exp_q.size() == 0, "R6 sequence complete", exp_q.size(), 0);
  endtask

  task automatic end_session();
    @(negedge clk); sess_vld = 0;
    repeat (2) @(negedge clk);
    chk(chg_type == 0 && cur_code == 0 && !det_done, "R9 cleared", {chg_type, cur_code, det_done}, 0);
  endtask

  task automatic pulse_upd(input logic [1:0] code);
    @(negedge clk); upd_vld = 1; upd_code = code;
    @(negedge clk); upd_vld = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(chg_type == 0 && cur_code == 0 && !det_done && !reg_req, "R1 reset",
        {chg_type, cur_code, det_done, reg_req}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!reg_req, "R1 idle without session", reg_req, 0);

    // standard port, contact at first poll; later update accepted
    run_case(1, 0, 0, 2'd1, 2'd1, 1);
    pulse_upd(2'd2);
    chk(cur_code == 2'd2, "R8 update on standard port", cur_code, 2);
    end_session();

    // charging data port after contact timeout
    run_case(0, 1, 0, 2'd2, 2'd2, TRIES);
    end_session();

    // dedicated charger, different field neighbours; update ignored
    reg04 = 8'hE7;
    run_case(1, 1, 1, 2'd3, 2'd2, 1);
    pulse_upd(2'd1);
    chk(cur_code == 2'd2, "R8 update ignored", cur_code, 2);
    end_session();

    // abort during contact polling
    contact = 0; polls = 0;
    push_seq(0);
    @(negedge clk); sess_vld = 1;
    for (int i = 0; i < 5000 && polls < 2; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    sess_vld = 0;
    exp_q.delete(); tag_q.delete();
    repeat (2) @(negedge clk);
    chk(chg_type == 0 && cur_code == 0 && !det_done && !reg_req, "R9 abort",
        {chg_type, cur_code, det_done, reg_req}, 0);
    repeat (40) @(negedge clk);
    chk(!reg_req && polls == 2, "R9 no access after abort", polls, 2);

    // restart after abort
    run_case(0, 1, 1, 2'd3, 2'd2, TRIES);
    chk(reg04 == 8'hE7, "R6 mode restored", reg04, 8'hE7);
    end_session();

    summary();
    $finish;
  end
endmodule